// File: doc/BRIEF.md
# Downstream Port Mapping Unit

This block decides which physical downstream port of a three-port hub answers to which logical port number. While reset is held, it captures two disable straps per physical port. A port drops out only when both of its straps read high. From the surviving ports it builds a gap-free logical numbering that starts at 1.

By default the logical order follows ascending physical number. A parallel remap table, captured on a load strobe, can impose any other order on top of that. Entries that cannot be honoured are skipped, and their slots are back-filled from the remaining enabled ports. The block publishes both lookup directions, the number of live ports and a per-port enable mask, all from registers.

Top module: `port_map_unit`

## Requirements
- R1: Physical port p (bit p-1 of the strap and mask vectors) is disabled exactly when both its D+ strap and D- strap were 1 at the last clock edge with reset asserted; `portEnable` bit p-1 is 1 for an enabled port.
- R2: Straps are sampled on every rising clock edge while `rstN` is low and are ignored after release until the next reset.
- R3: While `rstN` is low, every output reads 0.
- R4: `portCount` equals the number of enabled ports (0 to 3) and, like all outputs, is valid after the first rising edge following reset release.
- R5: With no accepted remap entries, logical slot k (bits [2k-1:2k-2] of `logToPhys`) holds the k-th enabled physical port in ascending order for k up to `portCount`; higher slots read 0.
- R6: `remapTable` holds a 2-bit physical port number per logical slot, slot 1 in bits [1:0]. It is captured on a rising edge with `remapLoad` high, and all outputs show the new mapping after that same edge. Otherwise they hold their value.
- R7: A remap entry is rejected when it is 0, names a disabled port, names a port already taken by a lower slot, or belongs to a slot above `portCount`. Each unfilled slot, in ascending slot order, takes the lowest-numbered enabled port not yet taken.
- R8: `physToLog` field p (bits [2p-1:2p-2]) gives the logical number of physical port p, or 0 when that port is disabled, and is the exact inverse of `logToPhys`.
- R9: A captured table persists until the next load, and loading an all-zero table restores the default order. Reset clears the table.
- R10: A load strobe raised while reset is asserted has no effect on the mapping seen after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; straps are captured while it is low |
| strapDp | input | 3 | D+ disable strap per physical port |
| strapDm | input | 3 | D- disable strap per physical port |
| remapLoad | input | 1 | Capture strobe for the remap table |
| remapTable | input | 6 | Requested physical port per logical slot, slot 1 lowest |
| logToPhys | output | 6 | Physical port per logical slot, 0 when unused |
| physToLog | output | 6 | Logical number per physical port, 0 when disabled |
| portCount | output | 2 | Number of enabled ports |
| portEnable | output | 3 | Enable mask per physical port |

## Verification
The strap patterns cover all ports enabled, a single-strap port that must stay enabled, a hole in the middle, a hole at port 1 and all ports off. Together these separate the "both straps" rule from an "either strap" rule and show that compaction leaves no gaps. Remap tables cover a full permutation, duplicates and zero entries, and an entry pointing at a disabled port or at a slot above the count. These tell the back-fill order apart from a plain append. Strap changes after release and loads held during reset show that neither one leaks into the mapping.

// File: rtl/port_map_pkg.sv
package port_map_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // sample straps this edge
    logic refresh;   // reload output registers this edge
    logic useNew;    // take the table from the input pins
  } pmStrobe_t;

  typedef enum logic [0:0] {
    PM_SAMPLE = 1'b0,
    PM_RUN    = 1'b1
  } pmState_t;

endpackage

// File: rtl/port_map_ctrl.sv
module port_map_ctrl
  import port_map_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      remapLoad,
  output pmStrobe_t strobe,
  output logic      running
);

  pmState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PM_SAMPLE;
    else       state <= PM_RUN;
  end

  always_comb begin
    strobe.capture = !rstN;
    strobe.useNew  = rstN && remapLoad;
    strobe.refresh = rstN && ((state == PM_SAMPLE) || remapLoad);
  end

  assign running = (state == PM_RUN);

  // R4
  first_refresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PM_SAMPLE) |=> (state == PM_RUN));

endmodule

// File: rtl/port_map_resolve.sv
module port_map_resolve #(
  parameter  int NUM_PORTS = 3,
  localparam int IDX_W     = $clog2(NUM_PORTS + 1)
) (
  input  logic [NUM_PORTS-1:0]       portEn,
  input  logic [NUM_PORTS*IDX_W-1:0] orderTbl,
  output logic [NUM_PORTS*IDX_W-1:0] l2pOut,
  output logic [NUM_PORTS*IDX_W-1:0] p2lOut,
  output logic [IDX_W-1:0]           cntOut
);

  logic [NUM_PORTS-1:0] claimed;
  logic                 found;
  int                   cnt;
  int                   ent;

  always_comb begin
    claimed = '0;
    found   = 1'b0;
    cnt     = 0;
    ent     = 0;
    l2pOut  = '0;
    p2lOut  = '0;

    for (int p = 0; p < NUM_PORTS; p++) cnt += int'(portEn[p]);

    // accept requested entries
    for (int k = 0; k < NUM_PORTS; k++) begin
      ent = int'(orderTbl[k*IDX_W +: IDX_W]);
      if (k < cnt && ent >= 1 && ent <= NUM_PORTS) begin
        if (portEn[ent-1] && !claimed[ent-1]) begin
          l2pOut[k*IDX_W +: IDX_W] = IDX_W'(ent);
          claimed[ent-1] = 1'b1;
        end
      end
    end

    // back-fill open slots from lowest free enabled port
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (k < cnt && l2pOut[k*IDX_W +: IDX_W] == '0) begin
        found = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (!found && portEn[p] && !claimed[p]) begin
            l2pOut[k*IDX_W +: IDX_W] = IDX_W'(p + 1);
            claimed[p] = 1'b1;
            found = 1'b1;
          end
        end
      end
    end

    // inverse lookup
    for (int k = 0; k < NUM_PORTS; k++) begin
      ent = int'(l2pOut[k*IDX_W +: IDX_W]);
      if (k < cnt && ent >= 1 && ent <= NUM_PORTS)
        p2lOut[(ent-1)*IDX_W +: IDX_W] = IDX_W'(k + 1);
    end

    cntOut = IDX_W'(cnt);
  end

endmodule

// File: rtl/port_map_dp.sv
module port_map_dp
  import port_map_pkg::*;
#(
  parameter  int NUM_PORTS = 3,
  localparam int IDX_W     = $clog2(NUM_PORTS + 1),
  localparam int TBL_W     = NUM_PORTS * IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pmStrobe_t            strobe,
  input  logic [NUM_PORTS-1:0] strapDp,
  input  logic [NUM_PORTS-1:0] strapDm,
  input  logic [TBL_W-1:0]     remapTable,
  output logic [TBL_W-1:0]     logToPhys,
  output logic [TBL_W-1:0]     physToLog,
  output logic [IDX_W-1:0]     portCount,
  output logic [NUM_PORTS-1:0] portEnable
);

  logic [NUM_PORTS-1:0] enLatch;
  logic [TBL_W-1:0]     tblReg;
  logic [TBL_W-1:0]     tblSel;
  logic [TBL_W-1:0]     l2pNext;
  logic [TBL_W-1:0]     p2lNext;
  logic [IDX_W-1:0]     cntNext;

  // strap capture: clocked while reset is held, no reset of its own
  always_ff @(posedge clk) begin
    if (strobe.capture) enLatch <= ~(strapDp & strapDm);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tblReg <= '0;
    else if (strobe.useNew) tblReg <= remapTable;
  end

  assign tblSel = strobe.useNew ? remapTable : tblReg;

  port_map_resolve #(.NUM_PORTS(NUM_PORTS)) uResolve (
    .portEn  (enLatch),
    .orderTbl(tblSel),
    .l2pOut  (l2pNext),
    .p2lOut  (p2lNext),
    .cntOut  (cntNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      logToPhys  <= '0;
      physToLog  <= '0;
      portCount  <= '0;
      portEnable <= '0;
    end else if (strobe.refresh) begin
      logToPhys  <= l2pNext;
      physToLog  <= p2lNext;
      portCount  <= cntNext;
      portEnable <= enLatch;
    end
  end

  // R4
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(portCount) == $countones(portEnable));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPhys
    // R8
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      !portEnable[p] |-> (physToLog[p*IDX_W +: IDX_W] == '0));
    for (genvar k = 0; k < NUM_PORTS; k++) begin : gLog
      // R8
      inverse_map_chk: assert property (@(posedge clk) disable iff (!rstN)
        (portEnable[p] && physToLog[p*IDX_W +: IDX_W] == IDX_W'(k + 1))
          |-> (logToPhys[k*IDX_W +: IDX_W] == IDX_W'(p + 1)));
    end
  end

endmodule

// File: rtl/port_map_unit.sv
module port_map_unit
  import port_map_pkg::*;
#(
  parameter  int NUM_PORTS = 3,
  localparam int IDX_W     = $clog2(NUM_PORTS + 1),
  localparam int TBL_W     = NUM_PORTS * IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] strapDp,
  input  logic [NUM_PORTS-1:0] strapDm,
  input  logic                 remapLoad,
  input  logic [TBL_W-1:0]     remapTable,
  output logic [TBL_W-1:0]     logToPhys,
  output logic [TBL_W-1:0]     physToLog,
  output logic [IDX_W-1:0]     portCount,
  output logic [NUM_PORTS-1:0] portEnable
);

  pmStrobe_t strobe;
  logic      running;

  port_map_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .remapLoad(remapLoad),
    .strobe   (strobe),
    .running  (running)
  );

  port_map_dp #(.NUM_PORTS(NUM_PORTS)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .strapDp   (strapDp),
    .strapDm   (strapDm),
    .remapTable(remapTable),
    .logToPhys (logToPhys),
    .physToLog (physToLog),
    .portCount (portCount),
    .portEnable(portEnable)
  );

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |=> $stable(portEnable));

  // R6
  no_load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !remapLoad) |=> ($stable(logToPhys) && $stable(physToLog)));

endmodule

// File: tb/tb_port_map_unit.sv
`timescale 1ns/100ps
module tb_port_map_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] strapDp = '0;
  logic [2:0] strapDm = '0;
  logic       remapLoad = 1'b0;
  logic [5:0] remapTable = '0;
  logic [5:0] logToPhys;
  logic [5:0] physToLog;
  logic [1:0] portCount;
  logic [2:0] portEnable;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  port_map_unit dut (
    .clk(clk), .rstN(rstN), .strapDp(strapDp), .strapDm(strapDm),
    .remapLoad(remapLoad), .remapTable(remapTable),
    .logToPhys(logToPhys), .physToLog(physToLog),
    .portCount(portCount), .portEnable(portEnable)
  );

  function automatic logic [5:0] tbl(int s1, int s2, int s3);
    return {2'(s3), 2'(s2), 2'(s1)};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [2:0] mEn;
  int       mTbl[3];
  int       mL2p[3];
  int       mP2l[3];
  int       mCnt;
  bit       mRun;

  function automatic void modelResolve();
    int  free[$];
    bit  taken[4];
    mCnt = 0;
    foreach (taken[i]) taken[i] = 0;
    for (int p = 0; p < 3; p++) if (mEn[p]) mCnt++;
    for (int k = 0; k < 3; k++) begin
      int e = mTbl[k];
      mL2p[k] = 0;
      if (k < mCnt && e >= 1 && e <= 3 && mEn[e-1] && !taken[e]) begin
        mL2p[k] = e;
        taken[e] = 1;
      end
    end
    for (int p = 1; p <= 3; p++) if (mEn[p-1] && !taken[p]) free.push_back(p);
    for (int k = 0; k < mCnt; k++) if (mL2p[k] == 0) mL2p[k] = free.pop_front();
    for (int p = 0; p < 3; p++) mP2l[p] = 0;
    for (int k = 0; k < mCnt; k++) mP2l[mL2p[k]-1] = k + 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = ~(strapDp & strapDm);
      for (int k = 0; k < 3; k++) mTbl[k] = 0;
      mRun = 0;
    end else begin
      if (remapLoad)
        for (int k = 0; k < 3; k++) mTbl[k] = int'(remapTable[2*k +: 2]);
      if (!mRun || remapLoad) modelResolve();
      mRun = 1;
    end
  end

  // every-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rstN || !mRun) begin
        check("R3", "logToPhys in reset", int'(logToPhys), 0);
        check("R3", "physToLog in reset", int'(physToLog), 0);
        check("R3", "portCount in reset", int'(portCount), 0);
        check("R3", "portEnable in reset", int'(portEnable), 0);
      end else begin
        check("R1", "portEnable", int'(portEnable), int'(mEn));
        check("R4", "portCount", int'(portCount), mCnt);
        for (int k = 0; k < 3; k++)
          check("R7", $sformatf("logToPhys slot%0d", k+1), int'(logToPhys[2*k +: 2]), mL2p[k]);
        for (int p = 0; p < 3; p++)
          check("R8", $sformatf("physToLog port%0d", p+1), int'(physToLog[2*p +: 2]), mP2l[p]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic doReset(logic [2:0] dp, logic [2:0] dm);
    @(posedge clk); #1;
    rstN = 1'b0; strapDp = dp; strapDm = dm;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic loadTbl(logic [5:0] t);
    remapTable = t; remapLoad = 1'b1;
    @(posedge clk); #1;
    remapLoad = 1'b0; remapTable = '0;
  endtask

  task automatic expectMap(string req, int l1, int l2, int l3, int p1, int p2, int p3, int c);
    check(req, "slot1", int'(logToPhys[1:0]), l1);
    check(req, "slot2", int'(logToPhys[3:2]), l2);
    check(req, "slot3", int'(logToPhys[5:4]), l3);
    check(req, "phys1", int'(physToLog[1:0]), p1);
    check(req, "phys2", int'(physToLog[3:2]), p2);
    check(req, "phys3", int'(physToLog[5:4]), p3);
    check(req, "count", int'(portCount), c);
  endtask

  initial begin
    // R3: outputs zero during reset
    repeat (2) @(posedge clk); #1;
    expectMap("R3", 0, 0, 0, 0, 0, 0, 0);

    // R4 R5: all enabled, default order
    doReset(3'b000, 3'b000);
    expectMap("R5", 1, 2, 3, 1, 2, 3, 3);
    check("R1", "mask all on", int'(portEnable), 3'b111);

    // R1 R5 R8: port 2 fully strapped off -> compacted
    doReset(3'b010, 3'b010);
    expectMap("R5", 1, 3, 0, 1, 0, 2, 2);
    check("R1", "mask port2 off", int'(portEnable), 3'b101);

    // R2: strap changes after release ignored
    strapDp = 3'b111; strapDm = 3'b111;
    repeat (4) @(posedge clk); #1;
    check("R2", "mask after strap change", int'(portEnable), 3'b101);
    check("R2", "count after strap change", int'(portCount), 2);

    // R1: only one strap high keeps the port enabled
    doReset(3'b010, 3'b000);
    check("R1", "single strap mask", int'(portEnable), 3'b111);
    doReset(3'b000, 3'b100);
    check("R1", "single Dm strap mask", int'(portEnable), 3'b111);

    // R6: permutation, visible right after the sampling edge
    doReset(3'b000, 3'b000);
    remapTable = tbl(3, 1, 2); remapLoad = 1'b1;
    #1 check("R6", "unchanged before edge", int'(logToPhys), int'(tbl(1, 2, 3)));
    @(posedge clk); #1;
    remapLoad = 1'b0; remapTable = '0;
    expectMap("R6", 3, 1, 2, 2, 3, 1, 3);
    // R9: table persists
    repeat (3) @(posedge clk); #1;
    expectMap("R9", 3, 1, 2, 2, 3, 1, 3);

    // R7: zero and duplicate entries back-filled
    loadTbl(tbl(2, 0, 2));
    expectMap("R7", 2, 1, 3, 2, 1, 3, 3);

    // R9: all-zero table restores default
    loadTbl(tbl(0, 0, 0));
    expectMap("R9", 1, 2, 3, 1, 2, 3, 3);

    // R7: disabled target and slot beyond count
    doReset(3'b001, 3'b001);
    loadTbl(tbl(1, 3, 2));
    expectMap("R7", 2, 3, 0, 0, 1, 2, 2);

    // R4: all disabled
    doReset(3'b111, 3'b111);
    expectMap("R4", 0, 0, 0, 0, 0, 0, 0);
    check("R4", "mask all off", int'(portEnable), 0);

    // R10: load during reset ignored; R9 reset clears table
    doReset(3'b000, 3'b000);
    loadTbl(tbl(3, 2, 1));
    @(posedge clk); #1;
    rstN = 1'b0;
    remapTable = tbl(2, 3, 1); remapLoad = 1'b1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1; remapLoad = 1'b0; remapTable = '0;
    @(posedge clk); #1;
    expectMap("R10", 1, 2, 3, 1, 2, 3, 3);

    repeat (2) @(posedge clk); #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule